// File: doc/BRIEF.md
# PCI Base Address Window Decoder

This block turns the six base address registers of a PCI function into decoded address windows. Each register has a fixed size and a fixed type, either I/O or memory, and the command register enables each type. The block masks every register value down to a window base that is aligned to the window size. It then applies validity rules: a window whose base is zero, that wraps, or that reaches past the top of its address space is rejected. A rejected or disabled window is reported with an all-ones base and end.

The decoded windows are captured on an update pulse and held in registers. A per-register remap pulse reports each window whose effective base changed at that update. Incoming bus cycles carry an address and an I/O or memory flag. The block checks them combinationally against the held windows and returns a hit flag and the index of the matching register, with the lowest-numbered register winning an overlap.

One legacy case is handled. When the function's class code marks it as a storage controller with a fixed programming interface (class 0x0101), every 4-byte I/O window claims only the single byte at offset 2.

Top module: `bar_window_decoder`

## Requirements
- R1: A decoded window's base is the register value with its low log2(size) bits cleared, and its end is base + size − 1. Sizes are zero or a power of two.
- R2: An I/O window (type bit 1) is rejected when its end is not above its base, when its base is zero, or when its end is at or above IO_LIMIT (default 0x10000).
- R3: A memory window (type bit 0) is rejected when its end is not above its base, when its base is zero, or when its end is 0xFFFFFFFF.
- R4: An I/O window is inactive while cmd_i bit 0 is 0. A memory window is inactive while cmd_i bit 1 is 0.
- R5: A register with size zero is never active and never produces a hit.
- R6: When class_i is 0x0101, an I/O window of size 4 reports base and end both equal to window base + 2. Only that byte hits.
- R7: An inactive window reports base and end of all ones. In the cycle after an update pulse, remap_o[i] is 1 exactly when window i's reported base differs from its previous value. Otherwise remap_o is 0.
- R8: Window outputs change only at a clock edge where update_i is 1. Input changes without an update have no effect on the window outputs or on hits.
- R9: hit_o is 1 when an active window of the access's type (acc_is_io_i = 1 for I/O) contains acc_addr_i. hit_idx_o is the lowest such register index, and it is 0 when there is no hit. Both follow the address in the same cycle.
- R10: After reset every window is inactive with all-ones base and end, remap_o is 0 and hit_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bar_value_i | input | NUM_BARS*32 | Register values, register i at bits [32i+31:32i] |
| bar_size_i | input | NUM_BARS*32 | Window sizes in bytes, zero or a power of two |
| bar_is_io_i | input | NUM_BARS | Type per register: 1 I/O, 0 memory |
| cmd_i | input | 2 | Bit 0 enables I/O windows, bit 1 enables memory windows |
| class_i | input | 16 | Class code of the function |
| update_i | input | 1 | Capture decoded windows at this edge |
| acc_addr_i | input | 32 | Address of the incoming cycle |
| acc_is_io_i | input | 1 | Incoming cycle is I/O (1) or memory (0) |
| win_active_o | output | NUM_BARS | Window i active |
| win_base_o | output | NUM_BARS*32 | Reported base per window |
| win_end_o | output | NUM_BARS*32 | Reported end per window |
| remap_o | output | NUM_BARS | Window i's base changed at the last update |
| hit_o | output | 1 | Incoming address hits an active window |
| hit_idx_o | output | clog2(NUM_BARS) | Index of the winning window |

## Verification
The assertions check the following on every cycle. Any hit lies inside an active window of the selected index. A hit I/O window ends below the I/O limit, and a hit memory window never ends at the top address. Inactive windows carry all-ones bases. Remap pulses only follow an update, and window outputs hold between updates. The bench scenarios are needed for the arithmetic of masking and validity under random sizes and values, for the command-bit enables, and for the legacy single-byte narrowing. They are also needed for remap suppression when an identical configuration is applied twice, and for lowest-index priority on overlapping windows, because these depend on the chosen input histories.

// File: rtl/bar_dec_pkg.sv
// Package: shared constants and the window record used by every stage of
// the base address window decoder. Assumes 32-bit configuration addresses.
package bar_dec_pkg;
    localparam int ADDR_W = 32;

    // One decoded window: activity, type, reported first and last byte.
    typedef struct packed {
        logic              active;
        logic              is_io;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] last;
    } win_t;
endpackage

// File: rtl/bar_window_calc.sv
// Module: combinational decode of one base address register into a window.
// Masks the value to the size, applies the type-specific validity rules and
// the command enables, and narrows legacy storage I/O windows to one byte.
// Assumes size is zero or a power of two.
module bar_window_calc
    import bar_dec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_LIMIT      = 32'h0001_0000,
    parameter logic [15:0]       LEGACY_CLASS  = 16'h0101,
    parameter logic [ADDR_W-1:0] LEGACY_SIZE   = 32'd4,
    parameter logic [ADDR_W-1:0] LEGACY_OFFSET = 32'd2
) (
    input  logic [ADDR_W-1:0] value_i,
    input  logic [ADDR_W-1:0] size_i,
    input  logic              is_io_i,
    input  logic              io_en_i,
    input  logic              mem_en_i,
    input  logic [15:0]       class_i,
    output win_t              win_o
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] last;
    logic              shape_ok;
    logic              ok;
    logic              legacy;

    // Aligned base and last byte of the full window.
    always_comb begin
        mask = ~(size_i - 1'b1);
        base = value_i & mask;
        last = base + size_i - 1'b1;
    end

    // Validity: non-empty, non-wrapping, non-zero, inside the address space.
    always_comb begin
        shape_ok = (last > base) && (base != '0);
        if (size_i == '0) begin
            ok = 1'b0;
        end else if (is_io_i) begin
            ok = io_en_i && shape_ok && (last < IO_LIMIT);
        end else begin
            ok = mem_en_i && shape_ok && (last != '1);
        end
    end

    // Legacy storage controllers claim one byte of their small I/O windows.
    always_comb begin
        legacy = is_io_i && (class_i == LEGACY_CLASS) && (size_i == LEGACY_SIZE);
    end

    // Reported window: claimed range when valid, all ones otherwise.
    always_comb begin
        win_o.is_io = is_io_i;
        if (!ok) begin
            win_o.active = 1'b0;
            win_o.base   = '1;
            win_o.last   = '1;
        end else if (legacy) begin
            win_o.active = 1'b1;
            win_o.base   = base + LEGACY_OFFSET;
            win_o.last   = base + LEGACY_OFFSET;
        end else begin
            win_o.active = 1'b1;
            win_o.base   = base;
            win_o.last   = last;
        end
    end
endmodule

// File: rtl/bar_window_state.sv
// Module: holds the decoded windows between update pulses and flags each
// window whose reported base moved at an update. Assumes update is a
// single-cycle pulse; remap flags last one cycle per update.
module bar_window_state
    import bar_dec_pkg::*;
#(
    parameter int NUM_BARS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                update_i,
    input  win_t [NUM_BARS-1:0] win_d_i,
    output win_t [NUM_BARS-1:0] win_q_o,
    output logic [NUM_BARS-1:0] remap_o
);
    localparam win_t WIN_IDLE = '{active: 1'b0, is_io: 1'b0, base: '1, last: '1};

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
        // Capture window g on update and mark a base change.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q_o[g] <= WIN_IDLE;
                remap_o[g] <= 1'b0;
            end else if (update_i) begin
                win_q_o[g] <= win_d_i[g];
                remap_o[g] <= (win_d_i[g].base != win_q_o[g].base);
            end else begin
                remap_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bar_hit_select.sv
// Module: combinational address match against the held windows with a
// fixed priority: the lowest index among matching windows wins.
module bar_hit_select
    import bar_dec_pkg::*;
#(
    parameter int NUM_BARS = 6,
    localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input  win_t [NUM_BARS-1:0] win_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                is_io_i,
    output logic                hit_o,
    output logic [IDX_W-1:0]    hit_idx_o
);
    logic [NUM_BARS-1:0] match;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_cmp
        // Window g claims the access when active, same type and in range.
        always_comb begin
            match[g] = win_i[g].active && (win_i[g].is_io == is_io_i) &&
                       (addr_i >= win_i[g].base) && (addr_i <= win_i[g].last);
        end
    end

    // Priority pick: scanning downward leaves the lowest match in place.
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        for (int i = NUM_BARS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o     = 1'b1;
                hit_idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bar_window_decoder.sv
// Module: top of the base address window decoder. Decodes every register in
// parallel, holds the result on update pulses, reports base changes and
// matches incoming cycles. Assumes register i occupies slice i of each flat
// input and that sizes and types stay fixed while the function runs.
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int                NUM_BARS      = 6,
    parameter logic [ADDR_W-1:0] IO_LIMIT      = 32'h0001_0000,
    parameter logic [15:0]       LEGACY_CLASS  = 16'h0101,
    parameter logic [ADDR_W-1:0] LEGACY_SIZE   = 32'd4,
    parameter logic [ADDR_W-1:0] LEGACY_OFFSET = 32'd2,
    localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_value_i,
    input  logic [NUM_BARS*ADDR_W-1:0] bar_size_i,
    input  logic [NUM_BARS-1:0]        bar_is_io_i,
    input  logic [1:0]                 cmd_i,
    input  logic [15:0]                class_i,
    input  logic                       update_i,
    input  logic [ADDR_W-1:0]          acc_addr_i,
    input  logic                       acc_is_io_i,
    output logic [NUM_BARS-1:0]        win_active_o,
    output logic [NUM_BARS*ADDR_W-1:0] win_base_o,
    output logic [NUM_BARS*ADDR_W-1:0] win_end_o,
    output logic [NUM_BARS-1:0]        remap_o,
    output logic                       hit_o,
    output logic [IDX_W-1:0]           hit_idx_o
);
    win_t [NUM_BARS-1:0] win_d;
    win_t [NUM_BARS-1:0] win_q;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        bar_window_calc #(
            .IO_LIMIT     (IO_LIMIT),
            .LEGACY_CLASS (LEGACY_CLASS),
            .LEGACY_SIZE  (LEGACY_SIZE),
            .LEGACY_OFFSET(LEGACY_OFFSET)
        ) u_calc (
            .value_i (bar_value_i[g*ADDR_W +: ADDR_W]),
            .size_i  (bar_size_i[g*ADDR_W +: ADDR_W]),
            .is_io_i (bar_is_io_i[g]),
            .io_en_i (cmd_i[0]),
            .mem_en_i(cmd_i[1]),
            .class_i (class_i),
            .win_o   (win_d[g])
        );

        // Flatten held window g onto the output buses.
        always_comb begin
            win_active_o[g]                 = win_q[g].active;
            win_base_o[g*ADDR_W +: ADDR_W]  = win_q[g].base;
            win_end_o[g*ADDR_W +: ADDR_W]   = win_q[g].last;
        end
    end

    bar_window_state #(
        .NUM_BARS(NUM_BARS)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .update_i(update_i),
        .win_d_i (win_d),
        .win_q_o (win_q),
        .remap_o (remap_o)
    );

    bar_hit_select #(
        .NUM_BARS(NUM_BARS)
    ) u_hit (
        .win_i    (win_q),
        .addr_i   (acc_addr_i),
        .is_io_i  (acc_is_io_i),
        .hit_o    (hit_o),
        .hit_idx_o(hit_idx_o)
    );
endmodule

// File: rtl/bar_window_decoder_chk.sv
// Module: property checker for the window decoder, attached by bind.
// Observes only the top-level ports.
module bar_window_decoder_chk #(
    parameter int          NUM_BARS = 6,
    parameter logic [31:0] IO_LIMIT = 32'h0001_0000,
    localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   update_i,
    input logic [31:0]            acc_addr_i,
    input logic                   acc_is_io_i,
    input logic [NUM_BARS-1:0]    win_active_o,
    input logic [NUM_BARS*32-1:0] win_base_o,
    input logic [NUM_BARS*32-1:0] win_end_o,
    input logic [NUM_BARS-1:0]    remap_o,
    input logic                   hit_o,
    input logic [IDX_W-1:0]       hit_idx_o
);
    logic        sel_act;
    logic [31:0] sel_base;
    logic [31:0] sel_end;
    logic        idx_ok;

    // Window fields at the reported hit index.
    always_comb begin
        idx_ok   = (int'(hit_idx_o) < NUM_BARS);
        sel_act  = 1'b0;
        sel_base = '0;
        sel_end  = '0;
        if (idx_ok) begin
            sel_act  = win_active_o[hit_idx_o];
            sel_base = win_base_o[hit_idx_o*32 +: 32];
            sel_end  = win_end_o[hit_idx_o*32 +: 32];
        end
    end

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (win_active_o == '0) && (remap_o == '0));

    p_hit_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> idx_ok && sel_act && (acc_addr_i >= sel_base) && (acc_addr_i <= sel_end));

    p_idx_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (hit_idx_o == '0));

    p_io_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && acc_is_io_i) |-> (sel_end < IO_LIMIT));

    p_mem_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !acc_is_io_i) |-> (sel_end != 32'hFFFF_FFFF));

    p_remap_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_o != '0) |-> $past(update_i));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> $stable(win_base_o) && $stable(win_end_o) && $stable(win_active_o));

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
        p_idle_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !win_active_o[g] |-> (win_base_o[g*32 +: 32] == '1) && (win_end_o[g*32 +: 32] == '1));

        p_nonzero_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
            win_active_o[g] |-> (win_base_o[g*32 +: 32] != '0) &&
                                (win_end_o[g*32 +: 32] >= win_base_o[g*32 +: 32]));
    end
endmodule

bind bar_window_decoder bar_window_decoder_chk #(
    .NUM_BARS(NUM_BARS),
    .IO_LIMIT(IO_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .update_i    (update_i),
    .acc_addr_i  (acc_addr_i),
    .acc_is_io_i (acc_is_io_i),
    .win_active_o(win_active_o),
    .win_base_o  (win_base_o),
    .win_end_o   (win_end_o),
    .remap_o     (remap_o),
    .hit_o       (hit_o),
    .hit_idx_o   (hit_idx_o)
);

// File: tb/bar_window_decoder_tb.sv
module bar_window_decoder_tb;
    localparam int NB = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] bv [NB];
    logic [31:0] bs [NB];
    logic [NB-1:0] bio = '0;
    logic [1:0]  cmd = 2'b11;
    logic [15:0] cls = '0;
    logic        update = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_io = 1'b0;

    logic [NB*32-1:0] bar_value, bar_size;
    logic [NB-1:0]    win_active, remap;
    logic [NB*32-1:0] win_base, win_end;
    logic             hit;
    logic [2:0]       hit_idx;

    logic        m_act [NB];
    logic        m_io  [NB];
    logic [31:0] m_base [NB];
    logic [31:0] m_end  [NB];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            bar_value[i*32 +: 32] = bv[i];
            bar_size[i*32 +: 32]  = bs[i];
        end
    end

    bar_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .bar_value_i(bar_value), .bar_size_i(bar_size), .bar_is_io_i(bio),
        .cmd_i(cmd), .class_i(cls), .update_i(update),
        .acc_addr_i(acc_addr), .acc_is_io_i(acc_io),
        .win_active_o(win_active), .win_base_o(win_base), .win_end_o(win_end),
        .remap_o(remap), .hit_o(hit), .hit_idx_o(hit_idx)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected window from the requirements R1..R6.
    task automatic model_win(input logic [31:0] v, input logic [31:0] s, input logic io,
                             output logic a, output logic [31:0] b, output logic [31:0] e);
        logic [31:0] fb, fe;
        logic ok;
        fb = v & ~(s - 32'd1);
        fe = fb + s - 32'd1;
        if (s == 0) ok = 1'b0;
        else if (io) ok = cmd[0] && (fe > fb) && (fb != 0) && (fe < 32'h0001_0000);
        else ok = cmd[1] && (fe > fb) && (fb != 0) && (fe != 32'hFFFF_FFFF);
        a = ok;
        if (!ok) begin b = '1; e = '1; end
        else if (io && cls == 16'h0101 && s == 32'd4) begin b = fb + 2; e = fb + 2; end
        else begin b = fb; e = fe; end
    endtask

    task automatic commit(input string tag);
        logic a [NB];
        logic [31:0] b [NB];
        logic [31:0] e [NB];
        for (int i = 0; i < NB; i++) model_win(bv[i], bs[i], bio[i], a[i], b[i], e[i]);
        @(negedge clk); update = 1'b1;
        @(negedge clk); update = 1'b0;
        for (int i = 0; i < NB; i++) begin
            chk(tag, $sformatf("active[%0d]", i), {31'b0, win_active[i]}, {31'b0, a[i]});
            chk(tag, $sformatf("base[%0d]", i), win_base[i*32 +: 32], b[i]);
            chk(tag, $sformatf("end[%0d]", i), win_end[i*32 +: 32], e[i]);
            chk("R7", $sformatf("remap[%0d]", i), {31'b0, remap[i]}, {31'b0, (b[i] != m_base[i])});
            m_act[i] = a[i]; m_base[i] = b[i]; m_end[i] = e[i]; m_io[i] = bio[i];
        end
        @(negedge clk);
        chk("R7", "remap after one cycle", {26'b0, remap}, 32'd0);
    endtask

    task automatic probe(input string tag, input logic [31:0] a, input logic io);
        logic eh;
        logic [2:0] ei;
        acc_addr = a; acc_io = io;
        #1;
        eh = 1'b0; ei = '0;
        for (int i = NB - 1; i >= 0; i--)
            if (m_act[i] && m_io[i] == io && a >= m_base[i] && a <= m_end[i]) begin
                eh = 1'b1; ei = 3'(i);
            end
        chk(tag, $sformatf("hit @%h", a), {31'b0, hit}, {31'b0, eh});
        chk(tag, $sformatf("idx @%h", a), {29'b0, hit_idx}, {29'b0, ei});
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NB; i++) begin bv[i] = '0; bs[i] = '0; end
        bio = '0; cmd = 2'b11; cls = 16'h0000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        clear_cfg();
        for (int i = 0; i < NB; i++) begin
            m_act[i] = 1'b0; m_io[i] = 1'b0; m_base[i] = '1; m_end[i] = '1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "active", {26'b0, win_active}, 32'd0);
        chk("R10", "remap", {26'b0, remap}, 32'd0);
        chk("R10", "base0", win_base[31:0], 32'hFFFF_FFFF);
        probe("R10", 32'h0000_1000, 1'b0);

        // R1: masking of a memory register
        bv[0] = 32'h8000_1234; bs[0] = 32'h1000;
        commit("R1");
        chk("R1", "base0 value", win_base[31:0], 32'h8000_1000);
        chk("R1", "end0 value", win_end[31:0], 32'h8000_1FFF);
        probe("R1", 32'h8000_1FFF, 1'b0);
        probe("R9", 32'h8000_1FFF, 1'b1);

        // R4: command enables
        bio[1] = 1'b1; bv[1] = 32'h0000_C000; bs[1] = 32'h100; cmd = 2'b10;
        commit("R4");
        chk("R4", "io disabled", {31'b0, win_active[1]}, 32'd0);
        cmd = 2'b01;
        commit("R4");
        chk("R4", "mem disabled", {31'b0, win_active[0]}, 32'd0);
        chk("R4", "io enabled", {31'b0, win_active[1]}, 32'd1);
        cmd = 2'b11;

        // R2: I/O limits
        bv[1] = 32'h0000_FFF0; bs[1] = 32'h20;
        commit("R2");
        chk("R2", "top io ok", win_end[63:32], 32'h0000_FFFF);
        bv[1] = 32'h0001_0000;
        commit("R2");
        chk("R2", "io past limit", {31'b0, win_active[1]}, 32'd0);
        bv[1] = 32'h0000_0010;
        commit("R2");
        chk("R2", "io zero base", {31'b0, win_active[1]}, 32'd0);

        // R3: memory top and zero
        bv[2] = 32'hFFFF_F000; bs[2] = 32'h1000;
        commit("R3");
        chk("R3", "mem at top", {31'b0, win_active[2]}, 32'd0);
        bv[2] = 32'h0000_0800;
        commit("R3");
        chk("R3", "mem zero base", {31'b0, win_active[2]}, 32'd0);

        // R5: size zero
        bv[3] = 32'h4000_0000; bs[3] = 32'h0;
        commit("R5");
        chk("R5", "size zero", {31'b0, win_active[3]}, 32'd0);
        probe("R5", 32'h4000_0000, 1'b0);

        // R6: legacy single-byte window
        clear_cfg();
        bio[1] = 1'b1; bv[1] = 32'h0000_0170; bs[1] = 32'd4; cls = 16'h0101;
        commit("R6");
        chk("R6", "legacy base", win_base[63:32], 32'h0000_0172);
        chk("R6", "legacy end", win_end[63:32], 32'h0000_0172);
        probe("R6", 32'h0000_0172, 1'b1);
        probe("R6", 32'h0000_0170, 1'b1);
        cls = 16'h0200;
        commit("R6");
        chk("R6", "other class base", win_base[63:32], 32'h0000_0170);

        // R7: identical configuration twice gives no remap
        commit("R7");
        chk("R7", "no remap on repeat", {26'b0, remap}, 32'd0);

        // R8: inputs change without update
        bv[1] = 32'h0000_0200; bv[0] = 32'h9000_0000; bs[0] = 32'h100;
        repeat (3) @(negedge clk);
        chk("R8", "base1 held", win_base[63:32], 32'h0000_0170);
        chk("R8", "active0 held", {31'b0, win_active[0]}, 32'd0);
        probe("R8", 32'h9000_0010, 1'b0);

        // R9: overlap picks the lowest index, type must match
        clear_cfg();
        bv[2] = 32'h2000_0000; bs[2] = 32'h0001_0000;
        bv[4] = 32'h2000_0000; bs[4] = 32'h0000_1000;
        bio[5] = 1'b1; bv[5] = 32'h0000_2000; bs[5] = 32'h100;
        commit("R9");
        probe("R9", 32'h2000_0800, 1'b0);
        chk("R9", "overlap idx", {29'b0, hit_idx}, 32'd2);
        probe("R9", 32'h2000_8000, 1'b0);
        probe("R9", 32'h0000_2050, 1'b1);
        probe("R9", 32'h0000_2050, 1'b0);
        probe("R9", 32'h2001_0000, 1'b0);

        // Random configurations
        for (int it = 0; it < 60; it++) begin
            for (int i = 0; i < NB; i++) begin
                bio[i] = 1'($urandom % 2);
                if ($urandom % 8 == 0) bs[i] = 0;
                else if (bio[i]) bs[i] = 32'd1 << (2 + $urandom % 7);
                else bs[i] = 32'd1 << (4 + $urandom % 16);
                case ($urandom % 10)
                    0: bv[i] = 32'h0;
                    1: bv[i] = 32'hFFFF_FFFF;
                    default: bv[i] = bio[i] ? ($urandom & 32'h0001_FFFF) : $urandom;
                endcase
            end
            cmd = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
            cls = ($urandom % 3 == 0) ? 16'h0101 : 16'h0300;
            commit("R1");
            for (int k = 0; k < 8; k++) begin
                int j;
                logic [31:0] a;
                j = $urandom % NB;
                if (m_act[j]) a = m_base[j] + ($urandom % (m_end[j] - m_base[j] + 1));
                else a = $urandom;
                probe("R9", a, ($urandom % 5 == 0) ? ~m_io[j] : m_io[j]);
            end
            if (it % 10 == 0) begin
                probe("R9", m_end[it % NB] + 1, m_io[it % NB]);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule